// File: doc/BRIEF.md
# Multiplexed ADC scan sequencer

This block lets one analog-to-digital converter serve up to sixteen analog inputs. It steps an analog multiplexer through a configured run of channels, starting at channel 0 and counting up. On each step it drives the select lines and then waits a programmable number of clocks so the switched node can settle. Only then does it pulse the converter's start strobe. When the converter reports completion, the block tags the result word with the channel number and offers it on a valid/ready output. After that it moves to the next channel. Because the converter is shared, each channel is sampled at the conversion rate divided by the channel count. Ten channels at 1 kHz each therefore need 10 k conversions per second.

A simultaneous mode serves inputs that must be captured at the same instant. A common hold line freezes every per-channel sample-and-hold stage before the first channel is selected. The held values are then settled and converted one after another. Once the last one is done, hold is released, and a programmable acquisition window must pass before hold can be raised again. A scan starts on a start pulse, or repeats by itself in continuous mode. If the converter does not answer within a fixed number of clocks, a watchdog aborts the scan.

Top module: `mux_scan_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `mux_sel` is 0 and `hold`, `adc_soc`, `res_valid`, `scan_done` and `err_timeout` are all low.
- R2: Each time `mux_sel` changes, `adc_soc` rises exactly `cfg_settle`+1 clocks later. With `cfg_settle` = 0 there is still one clock between the two.
- R3: `adc_soc` is a single-cycle pulse. One pulse is issued per channel, and the channels are visited in ascending order from 0 to `cfg_last_ch`, where `cfg_last_ch` holds the channel count minus one.
- R4: Every result carries on `res_ch` the channel that was selected at its strobe, and on `res_data` the `adc_data` value present in the cycle `adc_done` was high. Each result is delivered exactly once, in scan order.
- R5: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_ch` and `res_data` stay unchanged. A stalled sink lets at most one further conversion start, after which no strobe is issued until the result is accepted.
- R6: With `cfg_simul` = 1, `hold` rises at scan start, before the first strobe, and stays high through every strobe of the scan. With `cfg_simul` = 0, `hold` stays low.
- R7: `hold` falls on the cycle `scan_done` pulses. In continuous simultaneous operation it rises again exactly `cfg_acq`+2 clocks after that fall, and never sooner.
- R8: `scan_done` is a one-cycle pulse in the cycle the last channel's result first appears on `res_valid`.
- R9: With `cfg_cont` = 1 at scan start, the next scan begins without a `start` pulse. A scan started with `cfg_cont` = 0 is the last one.
- R10: The configuration inputs are sampled only when a scan begins. Changing them during a scan does not alter that scan's channel count or settle delay.
- R11: If `adc_done` has not arrived `TMO_LIMIT` clocks after a strobe, `err_timeout` pulses at exactly that distance, `hold` is low, no result and no `scan_done` are produced, and the sequencer goes back to idle, where a later `start` runs a normal scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan when idle |
| cfg_last_ch | input | CH_W | Channel count minus one |
| cfg_settle | input | SETTLE_W | Settling clocks after a select change |
| cfg_acq | input | ACQ_W | Acquisition clocks after hold release |
| cfg_simul | input | 1 | Simultaneous hold mode |
| cfg_cont | input | 1 | Continuous rescan |
| adc_done | input | 1 | Conversion complete, data valid |
| adc_data | input | DATA_W | Conversion result |
| mux_sel | output | CH_W | Multiplexer channel select |
| hold | output | 1 | Common hold line to sample-and-hold stages |
| adc_soc | output | 1 | Start-of-conversion strobe |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Sink accepts result |
| res_ch | output | CH_W | Channel tag of result |
| res_data | output | DATA_W | Result data |
| scan_done | output | 1 | Last channel of scan delivered |
| err_timeout | output | 1 | Conversion watchdog expired, scan aborted |

## Verification
The assertions take the converter to be well behaved. It answers a strobe with `adc_done` no more than once, and never while no conversion is pending. `res_ready` may drop at any time. The bench's converter model answers each strobe after a fixed latency shorter than the watchdog limit. It stays silent only in the deliberate timeout case, and it builds each data word from the select lines it sees at the strobe, so a wrong channel shows up as a data miscompare. Configuration is changed mid-scan only in the test that checks it is ignored.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CONV,
    ST_PUSH,
    ST_ACQ
  } scan_state_e;
endpackage

// File: rtl/scan_down_ctr.sv
module scan_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign is_zero = (cnt_q == '0);

  a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> !is_zero);
endmodule

// File: rtl/scan_timeout.sv
module scan_timeout #(
  parameter int LIMIT = 64,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/scan_result_slot.sv
module scan_result_slot #(
  parameter int CH_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [CH_W-1:0]   push_ch,
  input  logic [DATA_W-1:0] push_data,
  output logic              free,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CH_W-1:0]   res_ch,
  output logic [DATA_W-1:0] res_data
);
  assign free = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_ch    <= '0;
      res_data  <= '0;
    end else if (push) begin
      res_valid <= 1'b1;
      res_ch    <= push_ch;
      res_data  <= push_data;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  a_r5_stall_stable: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_ch) && $stable(res_data)));

  a_r5_push_only_free: assert property (@(posedge clk) disable iff (rst)
    push |-> free);
endmodule

// File: rtl/mux_scan_seq.sv
module mux_scan_seq
  import scan_pkg::*;
#(
  parameter int CH_W      = 4,
  parameter int DATA_W    = 16,
  parameter int SETTLE_W  = 8,
  parameter int ACQ_W     = 8,
  parameter int TMO_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CH_W-1:0]   cfg_last_ch,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [ACQ_W-1:0]  cfg_acq,
  input  logic              cfg_simul,
  input  logic              cfg_cont,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic [CH_W-1:0]   mux_sel,
  output logic              hold,
  output logic              adc_soc,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CH_W-1:0]   res_ch,
  output logic [DATA_W-1:0] res_data,
  output logic              scan_done,
  output logic              err_timeout
);
  localparam int CNT_W = (SETTLE_W > ACQ_W) ? SETTLE_W : ACQ_W;

  scan_state_e         state_q;
  logic [CH_W-1:0]     sel_q, last_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [ACQ_W-1:0]    acq_q;
  logic                simul_q, cont_q;
  logic [DATA_W-1:0]   cap_q;
  logic                hold_q, soc_q, done_q, err_q;

  logic             go, is_last, slot_free, push_ok;
  logic             cnt_load, cnt_dec, cnt_zero, tmo_exp;
  logic [CNT_W-1:0] cnt_val;

  assign go        = (state_q == ST_IDLE) && (start || cont_q);
  assign is_last   = (sel_q == last_q);
  assign push_ok   = (state_q == ST_PUSH) && slot_free;
  assign cnt_load  = go || (push_ok && (!is_last || simul_q));
  assign cnt_val   = go      ? CNT_W'(cfg_settle) :
                     is_last ? CNT_W'(acq_q) : CNT_W'(settle_q);
  assign cnt_dec   = ((state_q == ST_SETTLE) || (state_q == ST_ACQ)) && !cnt_zero;

  scan_down_ctr #(.W(CNT_W)) u_delay (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .is_zero(cnt_zero)
  );

  scan_timeout #(.LIMIT(TMO_LIMIT)) u_wdog (
    .clk(clk), .rst(rst), .run(state_q == ST_CONV), .expired(tmo_exp)
  );

  scan_result_slot #(.CH_W(CH_W), .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst(rst), .push(push_ok), .push_ch(sel_q), .push_data(cap_q),
    .free(slot_free), .res_valid(res_valid), .res_ready(res_ready),
    .res_ch(res_ch), .res_data(res_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sel_q    <= '0;
      last_q   <= '0;
      settle_q <= '0;
      acq_q    <= '0;
      simul_q  <= 1'b0;
      cont_q   <= 1'b0;
      cap_q    <= '0;
      hold_q   <= 1'b0;
      soc_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      soc_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go) begin
          last_q   <= cfg_last_ch;
          settle_q <= cfg_settle;
          acq_q    <= cfg_acq;
          simul_q  <= cfg_simul;
          cont_q   <= cfg_cont;
          hold_q   <= cfg_simul;
          sel_q    <= '0;
          state_q  <= ST_SETTLE;
        end
        ST_SETTLE: if (cnt_zero) begin
          soc_q   <= 1'b1;
          state_q <= ST_CONV;
        end
        ST_CONV: if (adc_done) begin
          cap_q   <= adc_data;
          state_q <= ST_PUSH;
        end else if (tmo_exp) begin
          err_q   <= 1'b1;
          hold_q  <= 1'b0;
          cont_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        ST_PUSH: if (slot_free) begin
          if (is_last) begin
            done_q  <= 1'b1;
            hold_q  <= 1'b0;
            state_q <= simul_q ? ST_ACQ : ST_IDLE;
          end else begin
            sel_q   <= sel_q + 1'b1;
            state_q <= ST_SETTLE;
          end
        end
        ST_ACQ: if (cnt_zero) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mux_sel     = sel_q;
  assign hold        = hold_q;
  assign adc_soc     = soc_q;
  assign scan_done   = done_q;
  assign err_timeout = err_q;

  // Acquisition window checker: clocks spent with hold low after a completed scan.
  logic [CNT_W:0]   low_cnt_q;
  logic [ACQ_W-1:0] acq_chk_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q <= '0;
      acq_chk_q <= '0;
      armed_q   <= 1'b0;
    end else begin
      if (done_q && !hold_q) begin
        armed_q   <= 1'b1;
        low_cnt_q <= (CNT_W+1)'(1);
        acq_chk_q <= acq_q;
      end else begin
        if (hold_q) armed_q <= 1'b0;
        if (!hold_q && !(&low_cnt_q)) low_cnt_q <= low_cnt_q + 1'b1;
      end
    end
  end

  a_r7_acq_window: assert property (@(posedge clk) disable iff (rst)
    ($rose(hold) && armed_q && $past(simul_q)) |-> (low_cnt_q >= (CNT_W+1)'(acq_chk_q) + 1'b1));

  a_r2_sel_stable_at_soc: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_soc) |-> $stable(mux_sel));

  a_r3_soc_pulse: assert property (@(posedge clk) disable iff (rst)
    adc_soc |=> !adc_soc);

  a_r6_hold_at_soc: assert property (@(posedge clk) disable iff (rst)
    (adc_soc && simul_q) |-> hold);

  a_r8_done_with_result: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (res_valid && !hold));

  a_r11_abort_release: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> (!hold && !adc_soc && !scan_done));
endmodule

// File: tb/mux_scan_seq_tb.sv
module mux_scan_seq_tb_top;
  localparam int CH_W = 4;
  localparam int DATA_W = 16;
  localparam int TMO = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, start, cfg_simul, cfg_cont, adc_done, res_ready;
  logic [CH_W-1:0] cfg_last_ch, mux_sel, res_ch;
  logic [7:0] cfg_settle, cfg_acq;
  logic [DATA_W-1:0] adc_data, res_data;
  logic hold, adc_soc, res_valid, scan_done, err_timeout;

  mux_scan_seq #(.TMO_LIMIT(TMO)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_last_ch(cfg_last_ch),
    .cfg_settle(cfg_settle), .cfg_acq(cfg_acq), .cfg_simul(cfg_simul),
    .cfg_cont(cfg_cont), .adc_done(adc_done), .adc_data(adc_data),
    .mux_sel(mux_sel), .hold(hold), .adc_soc(adc_soc), .res_valid(res_valid),
    .res_ready(res_ready), .res_ch(res_ch), .res_data(res_data),
    .scan_done(scan_done), .err_timeout(err_timeout)
  );

  int vectors = 0, fails = 0;
  int cyc = 0;
  int done_cnt = 0, soc_total = 0, err_cnt = 0;
  int exp_settle = 0, exp_last = 0, hold_mode = 0, exp_acq = 0;
  bit acq_exact = 0;
  int adc_lat = 2;
  bit adc_mute = 0;
  logic [CH_W+DATA_W-1:0] exp_q[$];

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word_of(int ch, int tag);
    return 16'h5A00 + 16'(ch << 4) + 16'(tag & 15);
  endfunction

  always @(posedge clk) cyc++;

  // converter model: answers each strobe after adc_lat clocks
  int pend = 0;
  logic [DATA_W-1:0] held_word;
  always @(negedge clk) begin
    adc_done <= 1'b0;
    if (pend > 0) begin
      if (pend == 1) begin
        adc_done <= 1'b1;
        adc_data <= held_word;
      end
      pend--;
    end
    if (adc_soc && !adc_mute) begin
      pend = adc_lat;
      held_word = word_of(int'(mux_sel), done_cnt);
    end
  end

  // monitor / scoreboard
  logic [CH_W-1:0] prev_sel = '0;
  logic prev_soc = 0, prev_hold = 0;
  bit sel_fresh = 0;
  int sel_cyc = 0, soc_cyc = 0, fall_cyc = -1;
  always @(negedge clk) begin
    if (!rst) begin
      if (mux_sel != prev_sel) begin sel_fresh = 1; sel_cyc = cyc; end
      if (adc_soc && !prev_soc) begin
        soc_total++;
        soc_cyc = cyc;
        if (sel_fresh) chk(cyc - sel_cyc == exp_settle + 1, "R2 settle interval", cyc - sel_cyc, exp_settle + 1);
        sel_fresh = 0;
        chk(hold == (hold_mode == 1), "R6 hold at strobe", int'(hold), hold_mode);
      end
      if (adc_soc && prev_soc) chk(0, "R3 strobe width", 2, 1);
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected result", int'(res_ch), -1);
        else begin
          logic [CH_W+DATA_W-1:0] e;
          e = exp_q.pop_front();
          chk(res_ch == e[CH_W+DATA_W-1:DATA_W], "R4 channel tag", int'(res_ch), int'(e[CH_W+DATA_W-1:DATA_W]));
          chk(res_data == e[DATA_W-1:0], "R4 data", int'(res_data), int'(e[DATA_W-1:0]));
        end
      end
      if (scan_done) begin
        done_cnt++;
        chk(res_valid && res_ch == CH_W'(exp_last), "R8 done with last result", int'(res_ch), exp_last);
        chk(!hold, "R7 hold released at done", int'(hold), 0);
      end
      if (prev_hold && !hold) fall_cyc = cyc;
      if (!prev_hold && hold && acq_exact && fall_cyc >= 0)
        chk(cyc - fall_cyc == exp_acq + 2, "R7 acquisition window", cyc - fall_cyc, exp_acq + 2);
      if (err_timeout) begin
        err_cnt++;
        chk(cyc - soc_cyc == TMO, "R11 timeout distance", cyc - soc_cyc, TMO);
        chk(!hold, "R11 hold released", int'(hold), 0);
      end
    end
    prev_sel = mux_sel; prev_soc = adc_soc; prev_hold = hold;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_scans(int n);
    int target = done_cnt + n;
    while (done_cnt < target) @(negedge clk);
  endtask

  task automatic expect_scan(int last, int tag);
    for (int c = 0; c <= last; c++) exp_q.push_back({CH_W'(c), word_of(c, tag)});
  endtask

  task automatic run_scan(int last, int settle, bit simul, int acq);
    cfg_last_ch = CH_W'(last); cfg_settle = 8'(settle); cfg_simul = simul;
    cfg_acq = 8'(acq); cfg_cont = 1'b0;
    exp_last = last; exp_settle = settle; hold_mode = simul ? 1 : 0;
    expect_scan(last, done_cnt);
    pulse_start();
    wait_scans(1);
    repeat (acq + 6) @(negedge clk);
  endtask

  initial begin
    int base;
    rst = 1'b1; start = 0; cfg_simul = 0; cfg_cont = 0; res_ready = 1;
    cfg_last_ch = '0; cfg_settle = '0; cfg_acq = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mux_sel == 0 && !hold && !adc_soc, "R1 reset outputs", int'(mux_sel), 0);
    chk(!res_valid && !scan_done && !err_timeout, "R1 reset flags", int'(res_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mux_sel == 0 && !hold && !adc_soc && !res_valid, "R1 after release", int'(hold), 0);

    // R2 R3 R4 sequential scan
    base = soc_total;
    run_scan(3, 2, 0, 0);
    chk(soc_total - base == 4, "R3 strobe count", soc_total - base, 4);

    // R2 zero settle, single channel
    adc_lat = 1;
    run_scan(0, 0, 0, 0);

    // R6 simultaneous full 16-channel scan
    adc_lat = 3;
    run_scan(15, 1, 1, 5);

    // R10 config changed mid-scan
    cfg_last_ch = 4'd2; cfg_settle = 8'd3; cfg_simul = 0; cfg_cont = 0;
    exp_last = 2; exp_settle = 3; hold_mode = 0;
    expect_scan(2, done_cnt);
    base = done_cnt;
    pulse_start();
    repeat (2) @(negedge clk);
    cfg_last_ch = 4'd9; cfg_settle = 8'd0;
    wait_scans(1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && done_cnt == base + 1, "R10 channel count kept", exp_q.size(), 0);

    // R9 R7 continuous simultaneous
    cfg_last_ch = 4'd2; cfg_settle = 8'd1; cfg_simul = 1; cfg_acq = 8'd3; cfg_cont = 1;
    exp_last = 2; exp_settle = 1; hold_mode = 1; exp_acq = 3;
    fall_cyc = -1; acq_exact = 1;
    base = done_cnt;
    expect_scan(2, done_cnt);
    expect_scan(2, done_cnt + 1);
    pulse_start();
    wait_scans(1);
    cfg_cont = 0;
    wait_scans(1);
    repeat (60) @(negedge clk);
    acq_exact = 0;
    chk(done_cnt == base + 2, "R9 scan count", done_cnt - base, 2);

    // R5 stalled sink
    res_ready = 0;
    cfg_last_ch = 4'd3; cfg_settle = 8'd1; cfg_simul = 0; cfg_cont = 0;
    exp_last = 3; exp_settle = 1; hold_mode = 0;
    expect_scan(3, done_cnt);
    base = soc_total;
    pulse_start();
    repeat (200) @(negedge clk);
    chk(soc_total - base == 2, "R5 strobes while stalled", soc_total - base, 2);
    chk(res_valid && res_ch == 0, "R5 held result", int'(res_ch), 0);
    res_ready = 1;
    wait_scans(1);
    repeat (10) @(negedge clk);

    // R11 converter silence
    adc_mute = 1;
    cfg_simul = 1; hold_mode = 1; exp_settle = 1; cfg_last_ch = 4'd3;
    base = done_cnt;
    pulse_start();
    repeat (TMO + 20) @(negedge clk);
    chk(err_cnt == 1, "R11 error pulse", err_cnt, 1);
    chk(!res_valid && done_cnt == base, "R11 no result", int'(res_valid), 0);
    adc_mute = 0;
    run_scan(1, 0, 0, 0);

    chk(exp_q.size() == 0, "R4 all results delivered", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule